// File: doc/BRIEF.md
# Audio Codec Clock Generator

This block produces every clock an audio codec needs from one of two reference clocks. One control bit picks the source: the external master clock or the output of an on-chip frequency-locked loop. An enable bit gates the chosen source. A power-of-two divider then brings it down to the system clock, which software sets to run at 512 times the audio sample rate.

When the interface is the timing master, the block also produces the serial bit clock, a programmable division of the system clock. It produces the frame (left/right) clock as a fixed division of the bit clock by 64. An auxiliary clock output, meant for general-purpose pins, can take either the undivided source or the divided system clock and pass it through its own divider. That output switches on by itself whenever any pin is configured as a clock output.

All dividers count on the selected reference clock and drive registered outputs. A ratio of one passes the clock straight through. A new ratio is taken up only when the running period ends, so no shortened pulse reaches a pin. The configuration ports are plain static inputs.

Top module: `codec_clkgen`

## Requirements
- R1: `src_sel_i` = 0 selects `mclk_i` and `src_sel_i` = 1 selects `fll_clk_i` as the reference that every divider counts on. The source is changed only while `sys_en_i` is low.
- R2: While `sys_en_i` is low, all four clock outputs are low. After `sys_en_i` rises, the first reference edge is cycle 0, all outputs start low, and for a system ratio D ≥ 2 the system clock first goes high in cycle D/2.
- R3: The system divider ratio is 2^`sys_div_i` for codes 0 to 4; codes 5 to 7 act as 16. Duty is 50%. Ratio 1 passes the gated reference straight to `sysclk_o`, high in the reference high phase and low in its low phase.
- R4: In master mode the bit clock period is (`bclk_div_i`+1) system-clock periods. Each period starts low, is low for the rounded-up half and is high for the rounded-down half. Field value 0 passes the system clock through.
- R5: The frame clock is the bit clock divided by 64. It is low (left) for the first 32 bit-clock periods after start-up and high (right) for the next 32. It changes state only when the bit clock falls.
- R6: With `master_i` low, `bclk_o` and `lrclk_o` stay low.
- R7: `aux_sel_i` = 0 feeds the auxiliary divider with the gated reference, and `aux_sel_i` = 1 feeds it with the system clock. Its period is (`aux_div_i`+1) periods of that source, low first for the rounded-up half. Field value 0 passes the source through.
- R8: `auxclk_o` runs only while at least one bit of `pin_clk_sel_i` is set, and stays low while all bits are clear.
- R9: A change of a bit-clock, auxiliary or system ratio takes effect only when the running period of that divider ends. The period in progress finishes with the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | External master reference clock |
| fll_clk_i | input | 1 | Frequency-locked loop reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 1 | Reference select: 0 master clock, 1 loop clock |
| sys_en_i | input | 1 | System clock enable |
| sys_div_i | input | 3 | System divider code, ratio 2^code (max 16) |
| master_i | input | 1 | Master mode: enables bit and frame clocks |
| bclk_div_i | input | 4 | Bit clock ratio minus one, in system periods |
| aux_sel_i | input | 1 | Auxiliary source: 0 undivided, 1 system clock |
| aux_div_i | input | 4 | Auxiliary ratio minus one |
| pin_clk_sel_i | input | PINS | One bit per pin configured as clock output |
| sysclk_o | output | 1 | System clock |
| bclk_o | output | 1 | Serial bit clock |
| lrclk_o | output | 1 | Frame (left/right) clock |
| auxclk_o | output | 1 | Auxiliary clock for general-purpose pins |

## Verification
A vector table applies five settings of system code, bit-clock field, auxiliary field and auxiliary source. The high and low run lengths measured on each output show power-of-two scaling, even and odd bit-clock ratios (where the shorter high phase separates odd from even) and the two auxiliary sources. In that table, one ratio passes the bit clock through and one has the auxiliary divider count whole system periods. Directed runs count the cycles from enable to the first edge of each output. They check that the frame clock flips exactly as the bit clock falls, and they switch the reference so that a pass-through sampled on each phase tells the two sources apart. A further run changes the bit-clock ratio in the middle of a high phase, so that an early reload shows as a high run of the wrong length.

// File: rtl/codec_clkgen.sv
module codec_clkgen #(
  parameter int PINS       = 8,
  parameter int FRAME_HALF = 32,
  parameter int DIVW       = 4
) (
  input  logic            mclk_i,
  input  logic            fll_clk_i,
  input  logic            rst_ni,
  input  logic            src_sel_i,
  input  logic            sys_en_i,
  input  logic [2:0]      sys_div_i,
  input  logic            master_i,
  input  logic [DIVW-1:0] bclk_div_i,
  input  logic            aux_sel_i,
  input  logic [DIVW-1:0] aux_div_i,
  input  logic [PINS-1:0] pin_clk_sel_i,
  output logic            sysclk_o,
  output logic            bclk_o,
  output logic            lrclk_o,
  output logic            auxclk_o
);
  localparam int RW  = DIVW + 1;
  localparam int LRW = $clog2(2 * FRAME_HALF);

  logic src_clk, en_l, gsrc, aux_on;
  assign src_clk = src_sel_i ? fll_clk_i : mclk_i;
  assign aux_on  = |pin_clk_sel_i;

  always_ff @(negedge src_clk or negedge rst_ni)
    if (!rst_ni) en_l <= 1'b0;
    else         en_l <= sys_en_i;
  assign gsrc = src_clk & en_l;

  logic [RW-1:0] d_req, b_req, a_req;
  assign d_req = (int'(sys_div_i) >= DIVW) ? (RW'(1) << DIVW) : (RW'(1) << sys_div_i);
  assign b_req = RW'(bclk_div_i) + RW'(1);
  assign a_req = RW'(aux_div_i) + RW'(1);

  logic run_q, mrun_q, arun_q;
  logic [DIVW-1:0] sc, bc, ac;
  logic [LRW-1:0]  lc;
  logic [RW-1:0]   d_act, b_act, a_act;
  logic sys_q, bclk_q, lr_q, aux_q;

  logic sys_last, sys_start, b_last, bwrap, b_load, a_step, a_last, awrap, a_load;
  logic [DIVW-1:0] sc_n, bc_n, ac_n;
  logic [LRW-1:0]  lc_n;
  logic [RW-1:0]   d_nx, b_nx, a_nx;

  assign sys_last  = (sc == DIVW'(d_act - RW'(1)));
  assign sys_start = !run_q || sys_last;
  assign sc_n      = sys_start ? '0 : sc + DIVW'(1);
  assign d_nx      = sys_start ? d_req : d_act;

  assign b_last = (bc == DIVW'(b_act - RW'(1)));
  assign bwrap  = mrun_q && sys_start && b_last;
  assign b_load = !mrun_q || bwrap;
  assign bc_n   = !mrun_q ? '0 : (sys_start ? (b_last ? '0 : bc + DIVW'(1)) : bc);
  assign b_nx   = b_load ? b_req : b_act;
  assign lc_n   = !mrun_q ? '0 : lc + LRW'(bwrap);

  assign a_step = aux_sel_i ? sys_start : 1'b1;
  assign a_last = (ac == DIVW'(a_act - RW'(1)));
  assign awrap  = arun_q && a_step && a_last;
  assign a_load = !arun_q || awrap;
  assign ac_n   = !arun_q ? '0 : (a_step ? (a_last ? '0 : ac + DIVW'(1)) : ac);
  assign a_nx   = a_load ? a_req : a_act;

  always_ff @(posedge src_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; mrun_q <= 1'b0; arun_q <= 1'b0;
      sc <= '0; bc <= '0; ac <= '0; lc <= '0;
      d_act <= RW'(1); b_act <= RW'(1); a_act <= RW'(1);
      sys_q <= 1'b0; bclk_q <= 1'b0; lr_q <= 1'b0; aux_q <= 1'b0;
    end else begin
      run_q  <= sys_en_i;
      mrun_q <= sys_en_i && master_i;
      arun_q <= sys_en_i && aux_on;
      if (sys_en_i) begin
        sc    <= sc_n;
        d_act <= d_nx;
        sys_q <= ({1'b0, sc_n} >= (d_nx >> 1));
      end else begin
        sc    <= '0;
        d_act <= d_req;
        sys_q <= 1'b0;
      end
      if (sys_en_i && master_i) begin
        bc     <= bc_n;
        b_act  <= b_nx;
        lc     <= lc_n;
        bclk_q <= ({1'b0, bc_n} >= ((b_nx + RW'(1)) >> 1));
        lr_q   <= lc_n[LRW-1];
      end else begin
        bc     <= '0;
        b_act  <= b_req;
        lc     <= '0;
        bclk_q <= 1'b0;
        lr_q   <= 1'b0;
      end
      if (sys_en_i && aux_on) begin
        ac    <= ac_n;
        a_act <= a_nx;
        aux_q <= ({1'b0, ac_n} >= ((a_nx + RW'(1)) >> 1));
      end else begin
        ac    <= '0;
        a_act <= a_req;
        aux_q <= 1'b0;
      end
    end
  end

  assign sysclk_o = (d_act == RW'(1)) ? gsrc : sys_q;
  assign bclk_o   = (b_act == RW'(1)) ? (sysclk_o & mrun_q) : bclk_q;
  assign lrclk_o  = lr_q;
  assign auxclk_o = (a_act == RW'(1)) ? ((aux_sel_i ? sysclk_o : gsrc) & arun_q) : aux_q;
endmodule

module codec_clkgen_chk #(
  parameter int PINS = 8,
  parameter int DIVW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sys_en_i,
  input logic            master_i,
  input logic [DIVW-1:0] bclk_div_i,
  input logic [PINS-1:0] pin_clk_sel_i,
  input logic            sysclk_o,
  input logic            bclk_o,
  input logic            lrclk_o,
  input logic            auxclk_o
);
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_en_i && $past(!sys_en_i)) |-> (!sysclk_o && !bclk_o && !lrclk_o && !auxclk_o));

  a_r6_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_i && $past(!master_i)) |-> (!bclk_o && !lrclk_o));

  a_r8_aux_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_clk_sel_i == '0 && $past(pin_clk_sel_i == '0)) |-> !auxclk_o);

  a_r5_frame_on_bclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lrclk_o) && bclk_div_i != '0 && $past(bclk_div_i) != '0) |-> $fell(bclk_o));

  a_r5_frame_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lrclk_o) |-> $past(master_i));
endmodule

bind codec_clkgen codec_clkgen_chk #(.PINS(PINS), .DIVW(DIVW)) u_chk (
  .clk(src_clk), .rst_n(rst_ni), .sys_en_i(sys_en_i), .master_i(master_i),
  .bclk_div_i(bclk_div_i), .pin_clk_sel_i(pin_clk_sel_i), .sysclk_o(sysclk_o),
  .bclk_o(bclk_o), .lrclk_o(lrclk_o), .auxclk_o(auxclk_o)
);

// File: tb/codec_clkgen_bench.sv
`timescale 1ns/1ps
module codec_clkgen_bench;
  logic mclk = 0, fll = 0, rst_n = 0;
  logic src_sel = 0, en = 0, master = 0, asel = 0;
  logic [2:0] sdiv = 0;
  logic [3:0] bdiv = 0, adiv = 0;
  logic [7:0] pins = 0;
  logic sysclk, bclk, lrclk, auxclk;
  int n_run = 0, n_fail = 0;

  always #2 mclk = ~mclk;
  always #3 fll = ~fll;

  codec_clkgen u_codec_clkgen (
    .mclk_i(mclk), .fll_clk_i(fll), .rst_ni(rst_n), .src_sel_i(src_sel),
    .sys_en_i(en), .sys_div_i(sdiv), .master_i(master), .bclk_div_i(bdiv),
    .aux_sel_i(asel), .aux_div_i(adiv), .pin_clk_sel_i(pins),
    .sysclk_o(sysclk), .bclk_o(bclk), .lrclk_o(lrclk), .auxclk_o(auxclk));

  // sys code, bclk field, aux field, aux sel, bclk lo, bclk hi, aux lo, aux hi
  localparam int VEC[5][8] = '{
    '{1, 3, 2, 1,  4,  4,  4,  2},
    '{0, 4, 4, 0,  3,  2,  3,  2},
    '{2, 1, 1, 1,  4,  4,  4,  4},
    '{4, 2, 15, 0, 32, 16,  8,  8},
    '{3, 0, 6, 1,  4,  4, 32, 24}
  };

  task automatic step();
    if (src_sel) @(posedge fll); else @(posedge mclk);
    #1;
  endtask

  function automatic logic get(int w);
    case (w)
      0: return sysclk;
      1: return bclk;
      2: return lrclk;
      default: return auxclk;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(int w, output int lo, output int hi);
    int g = 0;
    while (get(w) !== 1'b0 && g < 20000) begin step(); g++; end
    while (get(w) !== 1'b1 && g < 20000) begin step(); g++; end
    hi = 0;
    while (get(w) === 1'b1 && g < 20000) begin hi++; step(); g++; end
    lo = 0;
    while (get(w) === 1'b0 && g < 20000) begin lo++; step(); g++; end
  endtask

  initial begin
    #700000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lo, hi, sys_rise, b_rise, lr_rise, b255, b256, cnt, cnt2;
    repeat (3) step();
    check("R2 reset outputs", {sysclk, bclk, lrclk, auxclk}, 0);
    rst_n = 1;
    step();

    // R3: ratio 1 passes the reference through
    sdiv = 0; en = 1;
    repeat (3) step();
    check("R3 passthrough high phase", sysclk, 1);
    @(negedge mclk); #1;
    check("R3 passthrough low phase", sysclk, 0);

    // vector table: R3, R4, R5, R7
    foreach (VEC[i]) begin
      en = 0; master = 0; pins = 0;
      repeat (3) step();
      sdiv = 3'(VEC[i][0]); bdiv = 4'(VEC[i][1]); adiv = 4'(VEC[i][2]); asel = VEC[i][3][0];
      en = 1; master = 1; pins = 8'h01;
      repeat (2) step();
      if (VEC[i][0] != 0) begin
        measure(0, lo, hi);
        check("R3 sysclk high run", hi, (1 << VEC[i][0]) / 2);
        check("R3 sysclk low run", lo, (1 << VEC[i][0]) / 2);
      end
      measure(1, lo, hi);
      check("R4 bclk low run", lo, VEC[i][4]);
      check("R4 bclk high run", hi, VEC[i][5]);
      measure(3, lo, hi);
      check("R7 aux low run", lo, VEC[i][6]);
      check("R7 aux high run", hi, VEC[i][7]);
      if (i < 2) begin
        measure(2, lo, hi);
        check("R5 frame low run", lo, 32 * (VEC[i][4] + VEC[i][5]));
        check("R5 frame high run", hi, 32 * (VEC[i][4] + VEC[i][5]));
      end
    end

    // R2 / R5: start-up phase and frame edge placement
    en = 0; master = 0;
    repeat (3) step();
    sdiv = 1; bdiv = 3; en = 1; master = 1;
    sys_rise = -1; b_rise = -1; lr_rise = -1; b255 = -1; b256 = -1;
    for (int k = 0; k < 300; k++) begin
      step();
      if (sysclk && sys_rise < 0) sys_rise = k;
      if (bclk && b_rise < 0) b_rise = k;
      if (lrclk && lr_rise < 0) lr_rise = k;
      if (k == 255) b255 = bclk;
      if (k == 256) b256 = bclk;
    end
    check("R2 first sysclk high cycle", sys_rise, 1);
    check("R4 first bclk high cycle", b_rise, 4);
    check("R5 left phase length", lr_rise, 256);
    check("R5 bclk high before frame edge", b255, 1);
    check("R5 bclk low at frame edge", b256, 0);

    // R9: ratio change mid high phase
    measure(1, lo, hi);
    while (bclk !== 1'b0) step();
    while (bclk !== 1'b1) step();
    bdiv = 1;
    hi = 0; while (bclk === 1'b1 && hi < 100) begin hi++; step(); end
    lo = 0; while (bclk === 1'b0 && lo < 100) begin lo++; step(); end
    cnt = 0; while (bclk === 1'b1 && cnt < 100) begin cnt++; step(); end
    check("R9 old ratio finishes high phase", hi, 4);
    check("R9 new ratio low run", lo, 2);
    check("R9 new ratio high run", cnt, 2);

    // R6: master off
    master = 0;
    cnt = 0;
    for (int k = 0; k < 200; k++) begin step(); cnt += int'(bclk) + int'(lrclk); end
    check("R6 bclk and lrclk held low", cnt, 0);

    // R8: aux output switched by pin selection
    pins = 0; asel = 0; adiv = 1;
    cnt = 0;
    for (int k = 0; k < 100; k++) begin step(); cnt += int'(auxclk); end
    check("R8 aux low without pins", cnt, 0);
    pins = 8'h20;
    measure(3, lo, hi);
    check("R8 aux low run with pin", lo, 1);
    check("R8 aux high run with pin", hi, 1);

    // R2: disable returns outputs low
    en = 0;
    repeat (3) step();
    check("R2 disabled outputs", {sysclk, bclk, lrclk, auxclk}, 0);

    // R1: switch to loop clock, pass-through follows it
    src_sel = 1;
    repeat (3) step();
    sdiv = 0; en = 1;
    repeat (3) step();
    cnt = 0; cnt2 = 0;
    for (int k = 0; k < 6; k++) begin
      step();
      cnt += int'(sysclk);
      @(negedge fll); #1;
      cnt2 += int'(sysclk);
    end
    check("R1 loop clock high phases", cnt, 6);
    check("R1 loop clock low phases", cnt2, 0);
    sdiv = 2;
    repeat (4) step();
    measure(0, lo, hi);
    check("R1 divided loop clock high", hi, 2);
    check("R1 divided loop clock low", lo, 2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule